// File: doc/BRIEF.md
# Codec Operating-Mode Decoder and Monitor Flags

This block sits beside a data codec and turns a written control byte into the signals that steer the rest of the codec. A three-bit mode field selects between normal operation, a loopback test mode that keeps the line quiet and feeds the transmit signal back into the receive path, a normal mode that also raises a general-purpose drive-point output for external circuitry, and an idle mode that parks both line-driver outputs in their inactive levels while the receiver keeps running.

Two active-low sticky monitor flags report events to the outside. The activity flag drops when the receive circuit signals that a SPACE has been seen at the start of data activity. The scan flag drops when an asynchronous scan input rises; that input passes through a two-flop synchroniser and a rising-edge detector first. Each flag is released by writing a one to its own clear bit. The clear bits act only on the cycle of the write and are never stored. The received data is also presented as the enable for an external open-drain pull-down.

Top module: `codec_mode_ctl`

## Requirements
- R1: After reset the mode is 0, act_n and scan_n are 1, drive_pt and loop_sel are 0, and the line outputs follow line_a_in and line_b_in.
- R2: A write (wr_en high at a rising edge) loads wr_data[4:2] as the mode. Bits 7:5 have no effect on it. A write of mode 6 (110) sets drive_pt high from the next cycle on.
- R3: drive_pt goes low in the cycle after a write that changes the mode to any value other than 6. Rewriting mode 6 while already in mode 6 leaves it high.
- R4: In mode 7 (111), dr1_out is 0 and dr2_out is 1 whatever the line inputs are, and loop_sel is 0.
- R5: In mode 5 (101), loop_sel is 1, dr1_out is 0 and dr2_out is 1.
- R6: In modes 0 to 4 and in mode 6, dr1_out equals line_a_in, dr2_out equals line_b_in, and loop_sel is 0.
- R7: space_det high at a rising edge drives act_n low from the next cycle, and it stays low after space_det falls.
- R8: A write with wr_data[1]=1 returns act_n to 1 in the next cycle. A write with only wr_data[0]=1 leaves act_n low.
- R9: A low-to-high change of scan_in, held for at least one clock, drives scan_n low after the third rising edge that samples it high. A falling scan_in has no effect.
- R10: A write with wr_data[0]=1 returns scan_n to 1 in the next cycle.
- R11: When a set event and its clear write arrive in the same cycle, the flag goes low (the set wins).
- R12: The clear bits are not stored. A set event after a clear write drops the flag again with no further write. A cycle with wr_en low changes neither the mode nor the flags.
- R13: nrz_pd is 1 exactly when rx_nrz is 0, without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 8 | Control byte: [4:2] mode, [1] clear activity, [0] clear scan |
| space_det | input | 1 | Receive circuit saw a SPACE (synchronous) |
| scan_in | input | 1 | Asynchronous scan input |
| rx_nrz | input | 1 | Received data in NRZ form |
| line_a_in | input | 1 | First line-driver level from the modulator |
| line_b_in | input | 1 | Second line-driver level from the modulator |
| dr1_out | output | 1 | First line-driver output, gated by mode |
| dr2_out | output | 1 | Second line-driver output, gated by mode |
| loop_sel | output | 1 | Route transmit signal into the receive path |
| drive_pt | output | 1 | General-purpose drive-point output |
| act_n | output | 1 | Sticky data-activity flag, active low |
| scan_n | output | 1 | Sticky scan-event flag, active low |
| nrz_pd | output | 1 | Pull-down enable for the open-drain NRZ output |

## Verification
The bench builds the block with its defaults: an 8-bit control byte, the mode field at bit 2, and two synchroniser stages on the scan path. With these values the mode codes 5, 6 and 7 and both clear bits sit at fixed positions in the byte the bench writes. The three-edge scan latency can then be counted exactly, and a clear can be made to collide with a set in the same cycle to show which one wins.

// File: rtl/codec_mode_pkg.sv
package codec_mode_pkg;

    localparam int CTRL_W    = 8;
    localparam int MODE_W    = 3;
    localparam int MODE_LSB  = 2;
    localparam int CLR_ACT_B = 1;
    localparam int CLR_SCN_B = 0;

    typedef enum logic [MODE_W-1:0] {
        MODE_N0     = 3'd0,
        MODE_N1     = 3'd1,
        MODE_N2     = 3'd2,
        MODE_N3     = 3'd3,
        MODE_N4     = 3'd4,
        MODE_LOOP   = 3'd5,
        MODE_DRIVE  = 3'd6,
        MODE_IDLE   = 3'd7
    } mode_e;

    typedef struct packed {
        logic a;
        logic b;
    } line_pair_t;

    localparam line_pair_t LINE_PARKED = '{a: 1'b0, b: 1'b1};

    function automatic logic line_parked(input mode_e m);
        return (m == MODE_IDLE) || (m == MODE_LOOP);
    endfunction

    function automatic mode_e mode_of(input logic [CTRL_W-1:0] d);
        return mode_e'(d[MODE_LSB +: MODE_W]);
    endfunction

endpackage

// File: rtl/codec_ctl_reg.sv
module codec_ctl_reg
    import codec_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output mode_e             mode_q,
    output logic              drive_pt,
    output logic              clr_act,
    output logic              clr_scan
);
    mode_e new_mode;

    always_comb begin
        new_mode = mode_of(wr_data);
        clr_act  = wr_en & wr_data[CLR_ACT_B];
        clr_scan = wr_en & wr_data[CLR_SCN_B];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_N0;
            drive_pt <= 1'b0;
        end else if (wr_en) begin
            mode_q <= new_mode;
            if (new_mode != mode_q)
                drive_pt <= (new_mode == MODE_DRIVE);
        end
    end

    // R2
    a_r2_drive_rise: assert property (@(posedge clk) disable iff (rst)
        (wr_en && new_mode == MODE_DRIVE) |=> drive_pt);
    // R3
    a_r3_drive_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && new_mode != mode_q && new_mode != MODE_DRIVE) |=> !drive_pt);
    // R12
    a_r12_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mode_q));

endmodule

// File: rtl/codec_sticky_flag.sv
module codec_sticky_flag #(
    parameter int SYNC_STAGES = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic ev_in,
    input  logic clr,
    output logic flag_n
);
    logic set_ev;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            logic                   prev_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q <= '0;
                    prev_q <= 1'b0;
                end else begin
                    sync_q[0] <= ev_in;
                    for (int i = 1; i < SYNC_STAGES; i++)
                        sync_q[i] <= sync_q[i-1];
                    prev_q <= sync_q[SYNC_STAGES-1];
                end
            end
            assign set_ev = sync_q[SYNC_STAGES-1] & ~prev_q;
        end else begin : g_direct
            assign set_ev = ev_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            flag_n <= 1'b1;
        else if (set_ev)
            flag_n <= 1'b0;
        else if (clr)
            flag_n <= 1'b1;
    end

    // R7 / R9 / R11: a set event always lands, even against a clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> !flag_n);
    // R8 / R10
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_ev) |=> flag_n);
    // R7: sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (!flag_n && !clr) |=> !flag_n);

endmodule

// File: rtl/codec_line_gate.sv
module codec_line_gate
    import codec_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  line_a_in,
    input  logic  line_b_in,
    output logic  dr1_out,
    output logic  dr2_out,
    output logic  loop_sel
);
    line_pair_t line_in, line_out;

    always_comb begin
        line_in  = '{a: line_a_in, b: line_b_in};
        line_out = line_parked(mode) ? LINE_PARKED : line_in;
        loop_sel = (mode == MODE_LOOP);
    end

    assign dr1_out = line_out.a;
    assign dr2_out = line_out.b;

    // R4
    a_r4_idle_park: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IDLE) |-> (!dr1_out && dr2_out && !loop_sel));
    // R5
    a_r5_loop_park: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOOP) |-> (loop_sel && !dr1_out && dr2_out));
    // R6
    a_r6_pass: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_LOOP && mode != MODE_IDLE) |->
            (dr1_out == line_a_in && dr2_out == line_b_in && !loop_sel));

endmodule

// File: rtl/codec_mode_ctl.sv
module codec_mode_ctl
    import codec_mode_pkg::*;
#(
    parameter int SCAN_SYNC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              space_det,
    input  logic              scan_in,
    input  logic              rx_nrz,
    input  logic              line_a_in,
    input  logic              line_b_in,
    output logic              dr1_out,
    output logic              dr2_out,
    output logic              loop_sel,
    output logic              drive_pt,
    output logic              act_n,
    output logic              scan_n,
    output logic              nrz_pd
);
    mode_e mode_q;
    logic  clr_act, clr_scan;

    codec_ctl_reg u_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .mode_q(mode_q), .drive_pt(drive_pt),
        .clr_act(clr_act), .clr_scan(clr_scan)
    );

    codec_sticky_flag #(.SYNC_STAGES(0)) u_act (
        .clk(clk), .rst(rst), .ev_in(space_det), .clr(clr_act), .flag_n(act_n)
    );

    codec_sticky_flag #(.SYNC_STAGES(SCAN_SYNC)) u_scan (
        .clk(clk), .rst(rst), .ev_in(scan_in), .clr(clr_scan), .flag_n(scan_n)
    );

    codec_line_gate u_gate (
        .clk(clk), .rst(rst), .mode(mode_q),
        .line_a_in(line_a_in), .line_b_in(line_b_in),
        .dr1_out(dr1_out), .dr2_out(dr2_out), .loop_sel(loop_sel)
    );

    assign nrz_pd = ~rx_nrz;

    // R13
    a_r13_nrz: assert property (@(posedge clk) disable iff (rst)
        nrz_pd != rx_nrz);

endmodule

// File: tb/test_codec_mode_ctl.sv
module test_codec_mode_ctl;
    logic clk = 0, rst = 1;
    logic wr_en = 0, space_det = 0, scan_in = 0, rx_nrz = 1, la = 0, lb = 0;
    logic [7:0] wr_data = 0;
    logic dr1, dr2, loop_sel, drive_pt, act_n, scan_n, nrz_pd;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    codec_mode_ctl i_codec_mode_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .space_det(space_det), .scan_in(scan_in), .rx_nrz(rx_nrz),
        .line_a_in(la), .line_b_in(lb), .dr1_out(dr1), .dr2_out(dr2),
        .loop_sel(loop_sel), .drive_pt(drive_pt), .act_n(act_n),
        .scan_n(scan_n), .nrz_pd(nrz_pd)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    // {wr_en, data, la, lb, exp drive, loop, dr1, dr2}
    localparam int NV = 10;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 8'h18, 1'b1, 1'b0, 4'b1010},  // R2 mode 6
        {1'b1, 8'h18, 1'b0, 1'b1, 4'b1001},  // R3 rewrite 6 keeps drive
        {1'b0, 8'h1C, 1'b1, 1'b1, 4'b1011},  // R12 no strobe ignored
        {1'b1, 8'h1C, 1'b1, 1'b0, 4'b0001},  // R4 idle parks, R3 drop
        {1'b1, 8'h14, 1'b1, 1'b0, 4'b0101},  // R5 loopback
        {1'b1, 8'h0C, 1'b1, 1'b1, 4'b0011},  // R6 mode 3 passes
        {1'b1, 8'h18, 1'b0, 1'b0, 4'b1000},  // R6 mode 6 passes
        {1'b1, 8'h00, 1'b1, 1'b0, 4'b0010},  // R3 to mode 0
        {1'b1, 8'hF8, 1'b1, 1'b1, 4'b1011},  // R2 bits 7:5 ignored
        {1'b1, 8'hE0, 1'b0, 1'b1, 4'b0001}   // R2 back to mode 0
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        la = 1; lb = 0;
        @(negedge clk);
        chk("R1 reset", {drive_pt, loop_sel, dr1, dr2}, 4'b0010);
        chk("R1 flags", {2'b00, act_n, scan_n}, 4'b0011);

        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i][14]; wr_data = VEC[i][13:6];
            la = VEC[i][5]; lb = VEC[i][4];
            @(negedge clk);
            wr_en = 0;
            chk($sformatf("R2-6 vec %0d", i), {drive_pt, loop_sel, dr1, dr2}, VEC[i][3:0]);
        end

        // R13 open-drain enable
        rx_nrz = 0; #1;
        chk("R13 low", {3'b0, nrz_pd}, 4'b0001);
        rx_nrz = 1; #1;
        chk("R13 high", {3'b0, nrz_pd}, 4'b0000);

        // R7 activity flag
        space_det = 1; @(negedge clk); space_det = 0;
        chk("R7 set", {3'b0, act_n}, 4'b0000);
        @(negedge clk);
        chk("R7 sticky", {3'b0, act_n}, 4'b0000);
        wr(8'h01);
        chk("R8 wrong bit", {3'b0, act_n}, 4'b0000);
        wr(8'h02);
        chk("R8 clear", {3'b0, act_n}, 4'b0001);
        @(negedge clk);
        chk("R12 not stored", {3'b0, act_n}, 4'b0001);
        space_det = 1; @(negedge clk); space_det = 0;
        chk("R12 reset again", {3'b0, act_n}, 4'b0000);
        space_det = 1; wr(8'h02); space_det = 0;
        chk("R11 act set wins", {3'b0, act_n}, 4'b0000);
        wr(8'h02);

        // R9 scan flag latency
        scan_in = 1;
        @(negedge clk); @(negedge clk);
        chk("R9 not yet", {3'b0, scan_n}, 4'b0001);
        @(negedge clk);
        chk("R9 set", {3'b0, scan_n}, 4'b0000);
        wr(8'h01);
        chk("R10 clear", {3'b0, scan_n}, 4'b0001);
        scan_in = 0;
        repeat (5) @(negedge clk);
        chk("R9 fall ignored", {3'b0, scan_n}, 4'b0001);
        wr(8'h03);
        chk("R12 no strobe flag", {2'b0, act_n, scan_n}, 4'b0011);
        // R11 clear collides with scan set
        scan_in = 1;
        @(negedge clk); @(negedge clk);
        wr(8'h01);
        chk("R11 scan set wins", {3'b0, scan_n}, 4'b0000);
        wr(8'h01);
        chk("R10 clear after", {3'b0, scan_n}, 4'b0001);

        // R1 reset restores
        wr(8'h18);
        rst = 1; @(negedge clk); rst = 0;
        la = 0; lb = 1; #1;
        chk("R1 reset again", {drive_pt, loop_sel, dr1, dr2}, 4'b0001);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule